// File: doc/BRIEF.md
# Microprogram Sequencer with Dual Instruction Dispatch

This block is the next-state logic of a microcoded controller. It owns the control store address register. On each enabled clock it picks the address of the next control word from one of four sources. The sources are the next-address field of the current word, a two-way branch on the zero condition code, a dispatch on the instruction's addressing mode or register-form opcode, and a dispatch on a memory-operand opcode.

The two dispatches split every instruction's microprogram into two parts. The first dispatch ends each execution sequence. It enters either an address-mode sequence, for memory-operand instructions, or the execution sequence directly, for register-form instructions. The second dispatch ends each address-mode sequence and enters the execution sequence that matches the opcode. An opcode or mode with no entry sends the address to a fixed trap word and raises an illegal flag. Address 0 holds the instruction-fetch word and is the reset address.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_ni is low, cs_addr_o is 0 and illegal_o is 0.
- R2: With ready_i low, cs_addr_o and illegal_o keep their values across the clock.
- R3: When ready_i is high and nxt_type_i is 2'b00 (direct), the next cs_addr_o equals nxt_addr_i and illegal_o becomes 0.
- R4: When nxt_type_i is 2'b01 (conditional), the next address is nxt_addr_i when zero_i is 1. When zero_i is 0 it is nxt_addr_i+1, modulo 64. illegal_o becomes 0.
- R5: With nxt_type_i 2'b10, register-form opcodes dispatch straight to their execution entries. The opcode-to-address map is 0 branch-if-zero→10, 1 register load→12, 2 register store→13, 3/4/5 register add/sub/and→14 (one shared entry), 6 pop→16, 7 push→18.
- R6: With nxt_type_i 2'b10 and a memory opcode (8 to 13), amode_i 0 (base plus displacement, indirect) goes to 4 and amode_i 1 (register indirect) goes to 8.
- R7: With nxt_type_i 2'b11, the memory opcodes dispatch to execution entries. The map is 8 load→20, 9 store→22, 10/11/12 add/sub/and→24 (shared), 13 test→26.
- R8: An opcode of 14 or 15 under either dispatch is illegal. So is a register-form opcode under nxt_type_i 2'b11, and so is amode_i 2 or 3 for a memory opcode under 2'b10. Each of these sets cs_addr_o to the trap word 63 with illegal_o 1.
- R9: illegal_o stays 1 only until the next enabled clock, which clears it unless that clock's dispatch is illegal again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | Advance enable for the address register |
| nxt_type_i | input | 2 | Next-state type field of the current control word |
| nxt_addr_i | input | 6 | Next-address field of the current control word |
| opcode_i | input | 4 | Opcode field of the instruction register |
| amode_i | input | 2 | Addressing-mode field of the instruction register |
| zero_i | input | 1 | Zero condition code |
| cs_addr_o | output | 6 | Control store address |
| illegal_o | output | 1 | Current address came from an illegal dispatch |

## Verification
The hardest situations to reach are the illegal cases that depend on pairing a dispatch type with the wrong opcode group. Examples are a register-form opcode reaching the sequence dispatch, or a memory opcode with an unused mode reaching the first dispatch. A real microprogram never produces these pairings. The stimulus therefore drives the type field freely, independent of any fetched word, and forces each such pairing in directed steps. It then runs long random sweeps over type, opcode, mode, zero and ready. In these sweeps, stalls also land right after a trap and check that the flag holds.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned CS_AW = 6;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned MD_W  = 2;

  typedef logic [CS_AW-1:0] cs_addr_t;
  typedef logic [OP_W-1:0]  opc_t;
  typedef logic [MD_W-1:0]  amode_t;

  typedef enum logic [1:0] {
    NT_DIRECT = 2'b00,
    NT_COND   = 2'b01,
    NT_IDISP  = 2'b10,
    NT_SDISP  = 2'b11
  } nxt_type_e;

  // register-form opcodes
  localparam opc_t OPC_BZ   = 4'd0;
  localparam opc_t OPC_LR   = 4'd1;
  localparam opc_t OPC_STR  = 4'd2;
  localparam opc_t OPC_AR   = 4'd3;
  localparam opc_t OPC_SR   = 4'd4;
  localparam opc_t OPC_NR   = 4'd5;
  localparam opc_t OPC_POP  = 4'd6;
  localparam opc_t OPC_PUSH = 4'd7;
  // memory-operand opcodes
  localparam opc_t OPC_L    = 4'd8;
  localparam opc_t OPC_ST   = 4'd9;
  localparam opc_t OPC_A    = 4'd10;
  localparam opc_t OPC_S    = 4'd11;
  localparam opc_t OPC_N    = 4'd12;
  localparam opc_t OPC_T    = 4'd13;

  localparam amode_t AM_BDI = 2'd0;
  localparam amode_t AM_RI  = 2'd1;

  localparam cs_addr_t CS_FETCH = '0;
  localparam cs_addr_t CS_BDI   = 6'd4;
  localparam cs_addr_t CS_RI    = 6'd8;
  localparam cs_addr_t CS_BZ    = 6'd10;
  localparam cs_addr_t CS_LR    = 6'd12;
  localparam cs_addr_t CS_STR   = 6'd13;
  localparam cs_addr_t CS_ALURR = 6'd14;
  localparam cs_addr_t CS_POP   = 6'd16;
  localparam cs_addr_t CS_PUSH  = 6'd18;
  localparam cs_addr_t CS_LM    = 6'd20;
  localparam cs_addr_t CS_STM   = 6'd22;
  localparam cs_addr_t CS_ALURM = 6'd24;
  localparam cs_addr_t CS_TEST  = 6'd26;
  localparam cs_addr_t CS_TRAP  = '1;

  typedef struct packed {
    logic     hit;
    cs_addr_t addr;
  } disp_t;
endpackage

// File: rtl/useq_ib_decoder.sv
module useq_ib_decoder
  import useq_pkg::*;
(
  input  opc_t   opcode_i,
  input  amode_t amode_i,
  output disp_t  disp_o
);
  always_comb begin
    disp_o = '{hit: 1'b1, addr: CS_TRAP};
    unique case (opcode_i)
      OPC_BZ:                   disp_o.addr = CS_BZ;
      OPC_LR:                   disp_o.addr = CS_LR;
      OPC_STR:                  disp_o.addr = CS_STR;
      OPC_AR, OPC_SR, OPC_NR:   disp_o.addr = CS_ALURR;
      OPC_POP:                  disp_o.addr = CS_POP;
      OPC_PUSH:                 disp_o.addr = CS_PUSH;
      OPC_L, OPC_ST, OPC_A,
      OPC_S, OPC_N, OPC_T: begin
        unique case (amode_i)
          AM_BDI:  disp_o.addr = CS_BDI;
          AM_RI:   disp_o.addr = CS_RI;
          default: disp_o.hit  = 1'b0;
        endcase
      end
      default:                  disp_o.hit = 1'b0;
    endcase
    if (!disp_o.hit) disp_o.addr = CS_TRAP;
  end
endmodule

// File: rtl/useq_sb_decoder.sv
module useq_sb_decoder
  import useq_pkg::*;
(
  input  opc_t  opcode_i,
  output disp_t disp_o
);
  always_comb begin
    disp_o = '{hit: 1'b1, addr: CS_TRAP};
    unique case (opcode_i)
      OPC_L:               disp_o.addr = CS_LM;
      OPC_ST:              disp_o.addr = CS_STM;
      OPC_A, OPC_S, OPC_N: disp_o.addr = CS_ALURM;
      OPC_T:               disp_o.addr = CS_TEST;
      default:             disp_o.hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
(
  input  nxt_type_e nxt_type_i,
  input  cs_addr_t  nxt_addr_i,
  input  logic      zero_i,
  input  disp_t     ib_i,
  input  disp_t     sb_i,
  output cs_addr_t  next_o,
  output logic      illegal_o
);
  always_comb begin
    next_o    = nxt_addr_i;
    illegal_o = 1'b0;
    unique case (nxt_type_i)
      NT_DIRECT: next_o = nxt_addr_i;
      NT_COND:   next_o = zero_i ? nxt_addr_i : nxt_addr_i + 1'b1;
      NT_IDISP: begin
        next_o    = ib_i.addr;
        illegal_o = !ib_i.hit;
      end
      NT_SDISP: begin
        next_o    = sb_i.addr;
        illegal_o = !sb_i.hit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic [1:0]       nxt_type_i,
  input  logic [CS_AW-1:0] nxt_addr_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [MD_W-1:0]  amode_i,
  input  logic             zero_i,
  output logic [CS_AW-1:0] cs_addr_o,
  output logic             illegal_o
);
  disp_t    ib_disp, sb_disp;
  cs_addr_t next_addr;
  logic     next_ill;
  cs_addr_t addr_q;
  logic     ill_q;

  useq_ib_decoder u_ib (
    .opcode_i (opcode_i),
    .amode_i  (amode_i),
    .disp_o   (ib_disp)
  );

  useq_sb_decoder u_sb (
    .opcode_i (opcode_i),
    .disp_o   (sb_disp)
  );

  useq_next_sel u_sel (
    .nxt_type_i (nxt_type_e'(nxt_type_i)),
    .nxt_addr_i (nxt_addr_i),
    .zero_i     (zero_i),
    .ib_i       (ib_disp),
    .sb_i       (sb_disp),
    .next_o     (next_addr),
    .illegal_o  (next_ill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= CS_FETCH;
      ill_q  <= 1'b0;
    end else if (ready_i) begin
      addr_q <= next_addr;
      ill_q  <= next_ill;
    end
  end

  assign cs_addr_o = addr_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
  import useq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic [1:0]       nxt_type_i,
  input logic [CS_AW-1:0] nxt_addr_i,
  input logic [OP_W-1:0]  opcode_i,
  input logic [MD_W-1:0]  amode_i,
  input logic             zero_i,
  input logic [CS_AW-1:0] cs_addr_o,
  input logic             illegal_o
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(cs_addr_o) && $stable(illegal_o));

  a_r3_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i == 2'b00 |=> cs_addr_o == $past(nxt_addr_i) && !illegal_o);

  a_r4_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i == 2'b01 && zero_i |=> cs_addr_o == $past(nxt_addr_i));

  a_r4_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i == 2'b01 && !zero_i
    |=> cs_addr_o == CS_AW'($past(nxt_addr_i) + 1'b1) && !illegal_o);

  a_r6_reg_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i == 2'b10 && opcode_i >= 4'd8 && opcode_i <= 4'd13 && amode_i == 2'd1
    |=> cs_addr_o == 6'd8);

  a_r7_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i == 2'b11 && opcode_i == 4'd13 |=> cs_addr_o == 6'd26 && !illegal_o);

  a_r8_trap_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> cs_addr_o == '1);

  a_r8_bad_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && nxt_type_i[1] && opcode_i >= 4'd14 |=> illegal_o);
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_i    (ready_i),
  .nxt_type_i (nxt_type_i),
  .nxt_addr_i (nxt_addr_i),
  .opcode_i   (opcode_i),
  .amode_i    (amode_i),
  .zero_i     (zero_i),
  .cs_addr_o  (cs_addr_o),
  .illegal_o  (illegal_o)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ready_i = 1'b0;
  logic [1:0] nxt_type_i = 2'b00;
  logic [5:0] nxt_addr_i = 6'd0;
  logic [3:0] opcode_i = 4'd0;
  logic [1:0] amode_i = 2'd0;
  logic       zero_i = 1'b0;
  logic [5:0] cs_addr_o;
  logic       illegal_o;

  int checks = 0;
  int fails  = 0;
  int exp_addr = 0;
  int exp_ill  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  useq_sequencer u_dut (
    .clk_i, .rst_ni, .ready_i, .nxt_type_i, .nxt_addr_i,
    .opcode_i, .amode_i, .zero_i, .cs_addr_o, .illegal_o
  );

  function automatic string req_of(int t, int op);
    if (t == 0) return "R3";
    if (t == 1) return "R4";
    if (op >= 14) return "R8";
    if (t == 2) return (op <= 7) ? "R5" : "R6";
    return (op >= 8) ? "R7" : "R8";
  endfunction

  // behavioural reference, evaluated at the clock edge
  task automatic model();
    int t  = nxt_type_i;
    int na = nxt_addr_i;
    int op = opcode_i;
    int md = amode_i;
    int a;
    int il = 0;
    if (!ready_i) return;
    case (t)
      0: a = na;
      1: a = zero_i ? na : (na + 1) % 64;
      2: begin
        if (op == 0) a = 10;
        else if (op == 1) a = 12;
        else if (op == 2) a = 13;
        else if (op <= 5) a = 14;
        else if (op == 6) a = 16;
        else if (op == 7) a = 18;
        else if (op <= 13 && md == 0) a = 4;
        else if (op <= 13 && md == 1) a = 8;
        else begin a = 63; il = 1; end
      end
      default: begin
        if (op == 8) a = 20;
        else if (op == 9) a = 22;
        else if (op >= 10 && op <= 12) a = 24;
        else if (op == 13) a = 26;
        else begin a = 63; il = 1; end
      end
    endcase
    exp_addr = a;
    exp_ill  = il;
  endtask

  task automatic compare(string req);
    checks++;
    if (int'(cs_addr_o) != exp_addr || int'(illegal_o) != exp_ill) begin
      fails++;
      $display("FAIL %s: addr=%0d ill=%0d expected addr=%0d ill=%0d",
               req, cs_addr_o, illegal_o, exp_addr, exp_ill);
    end
  endtask

  task automatic step(int t, int na, int op, int md, bit z, bit rdy);
    string req;
    @(negedge clk_i);
    nxt_type_i = 2'(t); nxt_addr_i = 6'(na); opcode_i = 4'(op);
    amode_i = 2'(md); zero_i = z; ready_i = rdy;
    req = rdy ? req_of(t, op) : "R2";
    if (rdy && exp_ill != 0) req = {req, "/R9"};
    @(posedge clk_i);
    model();
    #1;
    compare(req);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with inputs that would otherwise move the address
    ready_i = 1'b1; nxt_type_i = 2'b00; nxt_addr_i = 6'd33;
    repeat (3) @(posedge clk_i);
    #1;
    exp_addr = 0; exp_ill = 0;
    compare("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    ready_i = 1'b0;

    step(0, 37, 0, 0, 0, 1);   // R3
    step(0, 5, 0, 0, 0, 0);    // R2 stall
    step(1, 20, 0, 0, 1, 1);   // R4 taken
    step(1, 20, 0, 0, 0, 1);   // R4 fall through
    step(1, 63, 0, 0, 0, 1);   // R4 wrap to 0
    for (int op = 0; op < 8; op++) step(2, 0, op, 3, 0, 1);  // R5, mode ignored
    for (int op = 8; op < 14; op++) begin
      step(2, 0, op, 0, 0, 1); // R6
      step(2, 0, op, 1, 0, 1); // R6
      step(3, 0, op, 2, 0, 1); // R7
    end
    step(2, 0, 10, 2, 0, 1);   // R8 bad mode
    step(0, 9, 0, 0, 0, 0);    // R2 hold trap + flag
    step(0, 9, 0, 0, 0, 1);    // R9 cleared
    step(3, 0, 5, 0, 0, 1);    // R8 register opcode at SB
    step(3, 0, 14, 0, 0, 1);   // R8
    step(2, 0, 15, 0, 0, 1);   // R8 back to back
    step(1, 7, 0, 0, 1, 1);    // R9
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 15),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule